// File: doc/BRIEF.md
# Link Interrupt Flags and Retransmit Statistics

This block keeps the interrupt state of a packet radio link controller. The receive path, the transmit path and the retry logic report three kinds of event as one-cycle pulses: a payload has arrived, a packet has gone out, and a packet has used up all of its retries. Each event sets a sticky flag. Software clears a flag only by writing a 1 to its bit. A per-flag mask decides whether that flag may pull the active-low interrupt line.

The block also assembles a status byte. That byte carries the three flags, the pipe number of the payload at the head of the receive FIFO (or an "empty" code), and the transmit-FIFO-full indication. A second byte holds transmit statistics. Its upper nibble counts packets lost for good, saturates, and clears on a write to the channel register. Its lower nibble counts resends of the current payload and restarts with each new packet. While the retry-limit flag is up, the block holds off further transmission.

Top module: `link_irq_status`

## Requirements
- R1: After a synchronous reset, `irq_n` is 1, `tx_hold` is 0, and both `status` bits 6:1 (flags and pipe) and `observe` reflect zero flags and zero counters.
- R2: A flag is set by its event pulse and stays set until `w1c_wr` is high with a 1 in that flag's bit of `w1c_data`. Writing 0 to a bit, or 1 to a different bit, leaves it unchanged.
- R3: When an event and a write-1-to-clear of the same flag arrive in the same cycle, the flag ends up set.
- R4: `irq_n` is 0 exactly when some flag is set whose mask bit is 0. `irq_mask[2]`, `irq_mask[1]` and `irq_mask[0]` mask the receive, sent and retry-limit flags. A masked flag still reads as set in `status`.
- R5: With `auto_ack` high, the sent flag is set only by `ack_rcvd`, and `tx_done` alone does not set it. With `auto_ack` low, `tx_done` sets it.
- R6: `tx_hold` is 1 while the retry-limit flag is set, and returns to 0 the cycle after that flag is cleared.
- R7: `status[3:1]` shows `rx_pipe` (0 to 5) while `rx_empty` is 0, and shows 3'b111 while `rx_empty` is 1.
- R8: Status layout: bit 7 reads 0, bit 6 is the receive flag, bit 5 is the sent flag, bit 4 is the retry-limit flag, and bit 0 follows `tx_full`.
- R9: `observe[7:4]` counts `retry_max_evt` pulses and stops at 15.
- R10: `chan_wr` clears `observe[7:4]` on the next edge, even if a `retry_max_evt` arrives in the same cycle.
- R11: `observe[3:0]` counts `retx_pulse` pulses and stops at 15. `new_pkt` clears it on the next edge, even if a resend pulse arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_evt | input | 1 | Payload received pulse |
| tx_done | input | 1 | Packet transmitted pulse |
| ack_rcvd | input | 1 | Acknowledge received pulse |
| auto_ack | input | 1 | Auto-acknowledge enabled for the current pipe |
| retry_max_evt | input | 1 | Retry limit reached pulse |
| rx_pipe | input | 3 | Pipe number of the payload at the receive FIFO head |
| rx_empty | input | 1 | Receive FIFO empty |
| tx_full | input | 1 | Transmit FIFO full |
| retx_pulse | input | 1 | One resend of the current payload |
| new_pkt | input | 1 | Transmission of a new packet starts |
| chan_wr | input | 1 | Write strobe of the channel register |
| w1c_wr | input | 1 | Status write strobe |
| w1c_data | input | 3 | Write data for status bits 6:4; a 1 clears that flag |
| irq_mask | input | 3 | Mask bits for the receive, sent and retry-limit flags |
| irq_n | output | 1 | Interrupt, active low |
| tx_hold | output | 1 | Transmission blocked |
| status | output | 8 | Status byte |
| observe | output | 8 | Lost count (7:4) and resend count (3:0) |

## Verification
The flag path is exercised in four ways:
- A lone event, followed by idle cycles, shows that the flag stays set.
- Zero writes and writes to neighbouring bits show that a clear hits only its own bit.
- An event and a clear in the same cycle show which one wins.
- Mask changes with a set flag separate the flag's state from the interrupt line.

The sent flag is driven with a bare transmit-done and with an acknowledge, under both settings of auto-acknowledge, which shows the gating. Both counters are pushed past 15 to show saturation, and are hit with a clear in the same cycle as an increment. The pipe field is read with the FIFO empty and not empty.

// File: rtl/link_irq_status.sv
`timescale 1ns/100ps
module link_irq_status #(
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_evt,
  input  logic              tx_done,
  input  logic              ack_rcvd,
  input  logic              auto_ack,
  input  logic              retry_max_evt,
  input  logic [2:0]        rx_pipe,
  input  logic              rx_empty,
  input  logic              tx_full,
  input  logic              retx_pulse,
  input  logic              new_pkt,
  input  logic              chan_wr,
  input  logic              w1c_wr,
  input  logic [2:0]        w1c_data,
  input  logic [2:0]        irq_mask,
  output logic              irq_n,
  output logic              tx_hold,
  output logic [7:0]        status,
  output logic [2*CNT_W-1:0] observe
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [2:0]       PIPE_NONE = 3'b111;

  // flags[2] receive, flags[1] sent, flags[0] retry limit
  logic [2:0]       flags;
  logic [CNT_W-1:0] lost_cnt;
  logic [CNT_W-1:0] retx_cnt;

  wire       sent_evt = auto_ack ? ack_rcvd : tx_done;
  wire [2:0] set_v    = {rx_evt, sent_evt, retry_max_evt};
  wire [2:0] clr_v    = w1c_wr ? w1c_data : 3'b000;

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~clr_v) | set_v;
  end

  always_ff @(posedge clk) begin
    if (rst || chan_wr)                       lost_cnt <= '0;
    else if (retry_max_evt && lost_cnt != CNT_MAX) lost_cnt <= lost_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || new_pkt)                       retx_cnt <= '0;
    else if (retx_pulse && retx_cnt != CNT_MAX)    retx_cnt <= retx_cnt + 1'b1;
  end

  assign irq_n   = ~|(flags & ~irq_mask);
  assign tx_hold = flags[0];
  assign status  = {1'b0, flags, rx_empty ? PIPE_NONE : rx_pipe, tx_full};
  assign observe = {lost_cnt, retx_cnt};

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (status[6] && !(w1c_wr && w1c_data[2])) |=> status[6]);

  assert_set_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (rx_evt && w1c_wr && w1c_data[2]) |=> status[6]);

  assert_irq_idle_R4: assert property (@(posedge clk) disable iff (rst)
    ((status[6:4] & ~irq_mask) == 3'b000) |-> irq_n);

  assert_ack_gate_R5: assert property (@(posedge clk) disable iff (rst)
    (auto_ack && !ack_rcvd && !status[5]) |=> !status[5]);

  assert_empty_code_R7: assert property (@(posedge clk) disable iff (rst)
    rx_empty |-> (status[3:1] == 3'b111));

  assert_lost_sat_R9: assert property (@(posedge clk) disable iff (rst)
    (observe[2*CNT_W-1:CNT_W] == CNT_MAX && !chan_wr) |=> (observe[2*CNT_W-1:CNT_W] == CNT_MAX));

  assert_lost_clr_R10: assert property (@(posedge clk) disable iff (rst)
    chan_wr |=> (observe[2*CNT_W-1:CNT_W] == '0));

  assert_retx_clr_R11: assert property (@(posedge clk) disable iff (rst)
    new_pkt |=> (observe[CNT_W-1:0] == '0));
endmodule

// File: tb/link_irq_status_bench.sv
`timescale 1ns/100ps
module link_irq_status_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 0, rx_evt = 0, tx_done = 0, ack_rcvd = 0, auto_ack = 0, retry_max_evt = 0;
  logic [2:0] rx_pipe = 0;
  logic rx_empty = 1, tx_full = 0, retx_pulse = 0, new_pkt = 0, chan_wr = 0, w1c_wr = 0;
  logic [2:0] w1c_data = 0, irq_mask = 0;
  logic irq_n, tx_hold;
  logic [7:0] status, observe;

  link_irq_status u_link_irq_status (
    .clk(clk), .rst(rst), .rx_evt(rx_evt), .tx_done(tx_done), .ack_rcvd(ack_rcvd),
    .auto_ack(auto_ack), .retry_max_evt(retry_max_evt), .rx_pipe(rx_pipe),
    .rx_empty(rx_empty), .tx_full(tx_full), .retx_pulse(retx_pulse), .new_pkt(new_pkt),
    .chan_wr(chan_wr), .w1c_wr(w1c_wr), .w1c_data(w1c_data), .irq_mask(irq_mask),
    .irq_n(irq_n), .tx_hold(tx_hold), .status(status), .observe(observe));

  // staging values, copied to the design at the falling edge
  logic s_rst = 0, s_rx = 0, s_done = 0, s_ack = 0, s_auto = 0, s_max = 0;
  logic [2:0] s_pipe = 0;
  logic s_empty = 1, s_full = 0, s_retx = 0, s_new = 0, s_chan = 0, s_wr = 0;
  logic [2:0] s_wd = 0, s_mask = 0;

  logic [2:0] m_flags = 0;
  int m_lost = 0, m_retx = 0;

  typedef struct packed { logic [7:0] st; logic [7:0] ob; logic irq; logic hold; } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic step(string tag);
    exp_t e;
    logic [2:0] set_v;
    @(negedge clk);
    rst = s_rst; rx_evt = s_rx; tx_done = s_done; ack_rcvd = s_ack; auto_ack = s_auto;
    retry_max_evt = s_max; rx_pipe = s_pipe; rx_empty = s_empty; tx_full = s_full;
    retx_pulse = s_retx; new_pkt = s_new; chan_wr = s_chan; w1c_wr = s_wr;
    w1c_data = s_wd; irq_mask = s_mask;
    s_rx = 0; s_done = 0; s_ack = 0; s_max = 0; s_retx = 0; s_new = 0; s_chan = 0; s_wr = 0;
    @(posedge clk);
    #0.5;
    if (rst) begin
      m_flags = 0; m_lost = 0; m_retx = 0;
    end else begin
      set_v = {rx_evt, auto_ack ? ack_rcvd : tx_done, retry_max_evt};
      m_flags = (m_flags & ~(w1c_wr ? w1c_data : 3'b000)) | set_v;
      if (chan_wr) m_lost = 0; else if (retry_max_evt && m_lost < 15) m_lost++;
      if (new_pkt) m_retx = 0; else if (retx_pulse && m_retx < 15) m_retx++;
    end
    e.st   = {1'b0, m_flags, rx_empty ? 3'b111 : rx_pipe, tx_full};
    e.ob   = {m_lost[3:0], m_retx[3:0]};
    e.irq  = ((m_flags & ~irq_mask) == 3'b000);
    e.hold = m_flags[0];
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor: compares each result one ns after the edge that produced it
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({status, observe, irq_n, tx_hold} !== e) begin
        errors++;
        $display("FAIL %s: got st=%h ob=%h irq_n=%b hold=%b exp st=%h ob=%h irq_n=%b hold=%b",
                 t, status, observe, irq_n, tx_hold, e.st, e.ob, e.irq, e.hold);
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    s_rst = 1; step("R1 reset"); step("R1 reset hold");
    s_rst = 0; step("R1 idle after reset");
    // pipe field and layout
    step("R7 empty code");
    s_empty = 0; s_pipe = 3; step("R7 pipe 3");
    s_pipe = 5; s_full = 1; step("R8 tx_full bit0 and pipe 5");
    s_full = 0; s_empty = 1;
    // flag set and clear
    s_rx = 1; step("R2 receive set");
    step("R2 receive hold");
    s_wr = 1; s_wd = 3'b000; step("R2 zero write ignored");
    s_wr = 1; s_wd = 3'b010; step("R2 other bit ignored");
    s_wr = 1; s_wd = 3'b100; step("R2 receive clear");
    // masking
    s_mask = 3'b100; s_rx = 1; step("R4 masked flag reads set, irq high");
    s_mask = 3'b000; step("R4 unmask pulls irq low");
    s_mask = 3'b011; step("R4 other masks leave irq low");
    s_mask = 3'b000;
    // set wins over clear
    s_rx = 1; s_wr = 1; s_wd = 3'b100; step("R3 set beats clear");
    s_wr = 1; s_wd = 3'b100; step("R3 later clear");
    // sent flag gating
    s_auto = 1; s_done = 1; step("R5 done without ack ignored");
    s_ack = 1; step("R5 ack sets sent");
    s_wr = 1; s_wd = 3'b010; step("R5 clear sent");
    s_auto = 0; s_done = 1; step("R5 done sets without auto ack");
    s_wr = 1; s_wd = 3'b010; step("R5 clear sent again");
    // retry limit blocks transmission
    s_max = 1; step("R6 retry limit sets hold");
    step("R6 hold persists");
    s_wr = 1; s_wd = 3'b001; step("R6 clear releases hold");
    // lost counter
    s_chan = 1; step("R10 clear before count");
    for (int i = 0; i < 17; i++) begin s_max = 1; step("R9 lost count / saturate"); end
    s_chan = 1; step("R10 channel write clears");
    s_max = 1; step("R9 count after clear");
    s_max = 1; s_chan = 1; step("R10 clear beats increment");
    s_wr = 1; s_wd = 3'b001; step("R6 clear flag");
    // resend counter
    for (int i = 0; i < 3; i++) begin s_retx = 1; step("R11 resend count"); end
    s_new = 1; step("R11 new packet clears");
    for (int i = 0; i < 17; i++) begin s_retx = 1; step("R11 resend saturate"); end
    s_retx = 1; s_new = 1; step("R11 clear beats increment");
    // reset with state present
    s_rx = 1; s_max = 1; s_retx = 1; step("R2 load before reset");
    s_rst = 1; step("R1 reset clears all");
    s_rst = 0; step("R1 idle");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule